// File: doc/BRIEF.md
# Dual-Compare Output Pulse Generator

This block drives one output pin from two compare values that are checked against a selectable time base. The primary compare value places the rising edge of a pulse and the secondary compare value places the falling edge. Each of the two internal time bases counts up while its run input is high and wraps to zero after reaching its own period value. The channel can produce a single pulse and then stay low, or a pulse on every period of the time base for as long as it runs.

Software programs the channel through a simple write port: a control word holding the mode, the time-base select and the interrupt enable, the two compare values, and the two period values. Writing a pulse mode into the control word arms the channel and pulls the pin low straight away. A sticky flag records every falling-edge compare event, and an interrupt request follows that flag when the enable bit is set.

Top module: `pulse_cmp_chan`

## Requirements
- R1: After reset the pin is low, the flag and interrupt request are low, both time bases hold 0, and the channel is disabled.
- R2: A write to address 0 whose bits [2:0] are 3'b100 (one-shot) or 3'b101 (repeating) arms the channel: the pin is low after the next clock edge, even if it was high, and the channel waits again for the primary match.
- R3: The primary compare value (address 1) and the secondary compare value (address 2) are matched against the selected time base; the pin goes high on the clock edge after the time base has advanced to the primary value, and low on the clock edge after it has advanced to the secondary value.
- R4: In one-shot mode (3'b100) exactly one pulse is produced; after its falling edge the pin stays low while the time base keeps running.
- R5: In one-shot mode a new pulse is armed by writing 3'b100 to bits [2:0] of address 0 again, with the time base still running and not cleared.
- R6: The flag is set on every secondary match while a pulse mode is active, stays set until a write to address 5 with bit 0 equal to 0 clears it, and a write to address 5 with bit 0 equal to 1 leaves it unchanged.
- R7: The interrupt request is high exactly when the flag is set and bit 4 of the control word (address 0) is 1.
- R8: Each time base adds one per clock while its run input is high, goes to 0 on the clock after it equals its period value (address 3 for time base 0, address 4 for time base 1), and holds its value while its run input is low.
- R9: Bit 3 of the control word selects the time base used for both compares: 0 picks time base 0, 1 picks time base 1; the other time base has no effect on the pin.
- R10: In repeating mode (3'b101) the rise and fall repeat on every pass of the time base, with a period of the period value plus one clocks.
- R11: A match counts only in the clock after the time base advanced; a stopped time base that holds the primary value produces one rising edge at most, and re-arming while it stays stopped produces none.
- R12: Any other value in bits [2:0] of address 0 disables the channel: the pin is low from the next edge on and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| tmr_run | input | 2 | Run enable, one bit per time base |
| pin_out | output | 1 | Compare output pin |
| irq_flag | output | 1 | Sticky secondary-match flag |
| irq_req | output | 1 | Interrupt request (flag gated by enable) |

## Verification
The assertions assume that the primary value lies strictly below the secondary value and both lie within the selected period, so that the rising and falling matches never fall into the same clock and a pulse is always closed before the time base wraps. They also assume that a control write and a flag-clear write never coincide with a secondary match, since write priority then decides the flag. The directed scenarios always configure with both time bases stopped right after reset, choose compare and period values inside those bounds, and place every in-flight control write away from the secondary match.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int unsigned AW = 3;
    localparam int unsigned NTB = 2;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_PRI  = 3'd1;
    localparam logic [AW-1:0] A_SEC  = 3'd2;
    localparam logic [AW-1:0] A_PER0 = 3'd3;
    localparam logic [AW-1:0] A_PER1 = 3'd4;
    localparam logic [AW-1:0] A_FLAG = 3'd5;

    localparam logic [2:0] MODE_ONE = 3'b100;
    localparam logic [2:0] MODE_RUN = 3'b101;

    localparam int unsigned CTRL_TSEL = 3;
    localparam int unsigned CTRL_IEN  = 4;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_SPENT
    } chan_st_e;

    typedef struct packed {
        chan_st_e st;
        logic     cont;
        logic     pin;
        logic     flag;
    } fsm_s;

endpackage

// File: rtl/pcg_timebase.sv
module pcg_timebase #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic          adv_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          adv;
    } tb_s;

    tb_s tb_d, tb_q;

    always_comb begin
        tb_d     = tb_q;
        tb_d.adv = run_i;
        if (run_i) begin
            if (tb_q.cnt == period_i) tb_d.cnt = '0;
            else                      tb_d.cnt = tb_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign cnt_o = tb_q.cnt;
    assign adv_o = tb_q.adv;

endmodule

// File: rtl/pcg_edge_fsm.sv
module pcg_edge_fsm
    import pcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic arm_cont_i,
    input  logic disarm_i,
    input  logic rise_hit_i,
    input  logic fall_hit_i,
    input  logic clr_i,
    output logic pin_o,
    output logic flag_o
);

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (arm_i) begin
            fsm_d.st   = ST_WAIT_HI;
            fsm_d.cont = arm_cont_i;
            fsm_d.pin  = 1'b0;
        end else if (disarm_i) begin
            fsm_d.st  = ST_OFF;
            fsm_d.pin = 1'b0;
        end else begin
            unique case (fsm_q.st)
                ST_WAIT_HI: if (rise_hit_i) begin
                    fsm_d.pin = 1'b1;
                    fsm_d.st  = ST_WAIT_LO;
                end
                ST_WAIT_LO: if (fall_hit_i) begin
                    fsm_d.pin = 1'b0;
                    fsm_d.st  = fsm_q.cont ? ST_WAIT_HI : ST_SPENT;
                end
                default: ;
            endcase
        end

        if (clr_i) fsm_d.flag = 1'b0;
        if (fall_hit_i && (fsm_q.st != ST_OFF) && !arm_i && !disarm_i)
            fsm_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{st: ST_OFF, cont: 1'b0, pin: 1'b0, flag: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign pin_o  = fsm_q.pin;
    assign flag_o = fsm_q.flag;

endmodule

// File: rtl/pulse_cmp_chan.sv
module pulse_cmp_chan
    import pcg_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    tmr_run,
    output logic          pin_out,
    output logic          irq_flag,
    output logic          irq_req
);

    typedef struct packed {
        logic                   ien;
        logic                   tsel;
        logic [CW-1:0]          pri;
        logic [CW-1:0]          sec;
        logic [NTB-1:0][CW-1:0] per;
    } regs_s;

    regs_s regs_d, regs_q;

    logic [NTB-1:0][CW-1:0] tb_cnt;
    logic [NTB-1:0]         tb_adv;
    logic [CW-1:0]          sel_cnt;
    logic                   sel_adv;
    logic                   wr_ctrl, mode_pulse, arm, disarm, clr;
    logic                   rise_hit, fall_hit;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    regs_d.tsel = wr_data[CTRL_TSEL];
                    regs_d.ien  = wr_data[CTRL_IEN];
                end
                A_PRI:  regs_d.pri    = wr_data;
                A_SEC:  regs_d.sec    = wr_data;
                A_PER0: regs_d.per[0] = wr_data;
                A_PER1: regs_d.per[1] = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    for (genvar g = 0; g < NTB; g++) begin : g_tb
        pcg_timebase #(.CW(CW)) u_tb (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (tmr_run[g]),
            .period_i (regs_q.per[g]),
            .cnt_o    (tb_cnt[g]),
            .adv_o    (tb_adv[g])
        );
    end

    always_comb begin
        sel_cnt    = tb_cnt[regs_q.tsel];
        sel_adv    = tb_adv[regs_q.tsel];
        rise_hit   = sel_adv && (sel_cnt == regs_q.pri);
        fall_hit   = sel_adv && (sel_cnt == regs_q.sec);
        wr_ctrl    = wr_en && (wr_addr == A_CTRL);
        mode_pulse = (wr_data[2:0] == MODE_ONE) || (wr_data[2:0] == MODE_RUN);
        arm        = wr_ctrl && mode_pulse;
        disarm     = wr_ctrl && !mode_pulse;
        clr        = wr_en && (wr_addr == A_FLAG) && !wr_data[0];
    end

    pcg_edge_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm),
        .arm_cont_i (wr_data[0]),
        .disarm_i   (disarm),
        .rise_hit_i (rise_hit),
        .fall_hit_i (fall_hit),
        .clr_i      (clr),
        .pin_o      (pin_out),
        .flag_o     (irq_flag)
    );

    assign irq_req = irq_flag & regs_q.ien;

endmodule

// File: rtl/pcg_chk.sv
module pcg_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [2:0]    wr_mode,
    input logic          run0,
    input logic          pin_out,
    input logic          irq_flag,
    input logic          irq_req,
    input logic [CW-1:0] sel_cnt,
    input logic          sel_adv,
    input logic [CW-1:0] pri,
    input logic [CW-1:0] sec,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] per0,
    input logic          ien
);

    logic ctrl_wr, pulse_wr;
    assign ctrl_wr  = wr_en && (wr_addr == 3'd0);
    assign pulse_wr = ctrl_wr && ((wr_mode == 3'b100) || (wr_mode == 3'b101));

    a_r2_arm_low: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_wr |=> !pin_out);

    a_r12_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !pulse_wr) |=> !pin_out);

    a_r3_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_out) |-> $past(sel_adv && (sel_cnt == pri)));

    a_r3_fall_src: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_out) |-> $past((sel_adv && (sel_cnt == sec)) || ctrl_wr));

    a_r6_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(sel_adv && (sel_cnt == sec)));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(wr_en && (wr_addr == 3'd5) && !wr_mode[0]));

    a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_flag && ien));

    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run0 && (cnt0 == per0)) |=> (cnt0 == '0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run0 |=> $stable(cnt0));

    a_r11_no_adv_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_adv && !ctrl_wr) |=> $stable(pin_out));

endmodule

bind pulse_cmp_chan pcg_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_mode  (wr_data[2:0]),
    .run0     (tmr_run[0]),
    .pin_out  (pin_out),
    .irq_flag (irq_flag),
    .irq_req  (irq_req),
    .sel_cnt  (sel_cnt),
    .sel_adv  (sel_adv),
    .pri      (regs_q.pri),
    .sec      (regs_q.sec),
    .cnt0     (tb_cnt[0]),
    .per0     (regs_q.per[0]),
    .ien      (regs_q.ien)
);

// File: tb/sim_pulse_cmp_chan.sv
`timescale 1ns/1ps
module sim_pulse_cmp_chan;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [1:0]    tmr_run = '0;
    logic          pin_out, irq_flag, irq_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    pulse_cmp_chan #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_run(tmr_run), .pin_out(pin_out),
        .irq_flag(irq_flag), .irq_req(irq_req)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        tmr_run = '0;
        wr_en = 1'b0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic [CW-1:0] ctrl_word(input logic [2:0] mode, input int sel, input bit ien);
        logic [CW-1:0] c;
        c = '0;
        c[2:0] = mode;
        c[3] = (sel == 1);
        c[4] = ien;
        return c;
    endfunction

    task automatic cfg(input int p, input int s, input int pr, input int sel, input bit cont, input bit ien);
        wr(3'd1, CW'(p));
        wr(3'd2, CW'(s));
        wr((sel == 1) ? 3'd4 : 3'd3, CW'(pr));
        wr(3'd0, ctrl_word(cont ? 3'b101 : 3'b100, sel, ien));
    endtask

    // Runs the selected time base from 0 for n edges; optional re-arm write at edge w.
    task automatic run_model(input int p, input int s, input int pr, input bit cont,
                             input bit ien, input int sel, input int n, input int w,
                             input string req);
        int   ph;
        logic epin;
        logic eflag;
        ph = 1;
        epin = 1'b0;
        eflag = 1'b0;
        tmr_run[sel] = 1'b1;
        for (int e = 1; e <= n; e++) begin
            bit wnow;
            wnow = (e == w);
            if (wnow) begin
                wr_addr = 3'd0;
                wr_data = ctrl_word(cont ? 3'b101 : 3'b100, sel, ien);
                wr_en = 1'b1;
            end
            tick();
            wr_en = 1'b0;
            if (wnow) begin
                ph = 1;
                epin = 1'b0;
            end else if (e >= 2) begin
                int v;
                v = (e - 1) % (pr + 1);
                if (ph == 1 && v == p) begin
                    ph = 2;
                    epin = 1'b1;
                end else if (ph == 2 && v == s) begin
                    epin = 1'b0;
                    ph = cont ? 1 : 3;
                end
                if (v == s) eflag = 1'b1;
            end
            chk(req, $sformatf("pin after edge %0d", e), pin_out, epin);
            chk(req, $sformatf("flag after edge %0d", e), irq_flag, eflag);
            chk(req, $sformatf("irq after edge %0d", e), irq_req, eflag & ien);
        end
        tmr_run = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "pin after reset", pin_out, 1'b0);
        chk("R1", "flag after reset", irq_flag, 1'b0);
        chk("R1", "irq after reset", irq_req, 1'b0);
    endtask

    task automatic t_single();
        do_reset();
        cfg(3, 7, 9, 0, 0, 0);
        run_model(3, 7, 9, 0, 0, 0, 35, 0, "R4");
        wr(3'd5, 16'h0000);
        chk("R6", "flag after clear", irq_flag, 1'b0);
    endtask

    task automatic t_edge_timing();
        do_reset();
        cfg(5, 6, 12, 0, 0, 0);
        run_model(5, 6, 12, 0, 0, 0, 16, 0, "R3");
    endtask

    task automatic t_cont();
        do_reset();
        cfg(2, 5, 7, 0, 1, 0);
        run_model(2, 5, 7, 1, 0, 0, 30, 0, "R10");
    endtask

    task automatic t_rearm();
        do_reset();
        cfg(4, 6, 9, 0, 0, 0);
        run_model(4, 6, 9, 0, 0, 0, 40, 23, "R5");
    endtask

    task automatic t_arm_high();
        do_reset();
        cfg(2, 5, 7, 0, 1, 0);
        run_model(2, 5, 7, 1, 0, 0, 24, 12, "R2");
    endtask

    task automatic t_irq();
        do_reset();
        cfg(3, 7, 9, 0, 1, 1);
        run_model(3, 7, 9, 1, 1, 0, 25, 0, "R7");
        wr(3'd5, 16'h0001);
        chk("R6", "flag after write of 1", irq_flag, 1'b1);
        chk("R7", "irq after write of 1", irq_req, 1'b1);
        wr(3'd5, 16'h0000);
        chk("R6", "flag after write of 0", irq_flag, 1'b0);
        chk("R7", "irq after clear", irq_req, 1'b0);
    endtask

    task automatic t_tsel();
        do_reset();
        wr(3'd1, 16'd2);
        wr(3'd2, 16'd4);
        wr(3'd3, 16'd9);
        wr(3'd4, 16'd5);
        wr(3'd0, ctrl_word(3'b101, 1, 0));
        tmr_run[0] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            chk("R9", $sformatf("pin with unselected base, step %0d", i), pin_out, 1'b0);
        end
        tmr_run = '0;
        chk("R9", "flag with unselected base", irq_flag, 1'b0);
        run_model(2, 4, 5, 1, 0, 1, 26, 0, "R9");
    endtask

    task automatic t_stopped();
        do_reset();
        cfg(3, 8, 15, 0, 0, 0);
        tmr_run[0] = 1'b1;
        tick();
        tick();
        tick();
        tmr_run[0] = 1'b0;
        tick();
        chk("R11", "rise on last advance", pin_out, 1'b1);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R8", $sformatf("pin held with base stopped, step %0d", i), pin_out, 1'b1);
        end
        wr(3'd0, ctrl_word(3'b100, 0, 0));
        chk("R2", "pin after re-arm", pin_out, 1'b0);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R11", $sformatf("no rise from held match, step %0d", i), pin_out, 1'b0);
        end
    endtask

    task automatic t_off();
        do_reset();
        cfg(2, 4, 6, 0, 1, 1);
        tmr_run[0] = 1'b1;
        tick();
        tick();
        tick();
        chk("R10", "pin high before disable", pin_out, 1'b1);
        wr(3'd0, ctrl_word(3'b110, 0, 1));
        chk("R12", "pin after disable", pin_out, 1'b0);
        for (int i = 0; i < 20; i++) begin
            tick();
            chk("R12", $sformatf("pin while disabled, step %0d", i), pin_out, 1'b0);
            chk("R12", $sformatf("flag while disabled, step %0d", i), irq_flag, 1'b0);
        end
        tmr_run = '0;
        do_reset();
        cfg(2, 4, 6, 0, 1, 1);
        wr(3'd0, ctrl_word(3'b111, 0, 1));
        tmr_run[0] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            chk("R12", $sformatf("pin in mode 111, step %0d", i), pin_out, 1'b0);
            chk("R12", $sformatf("irq in mode 111, step %0d", i), irq_req, 1'b0);
        end
        tmr_run = '0;
    endtask

    initial begin
        t_reset();
        t_single();
        t_edge_timing();
        t_cont();
        t_rearm();
        t_arm_high();
        t_irq();
        t_tsel();
        t_stopped();
        t_off();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule